// File: doc/BRIEF.md
# Modem status line scanner

This block watches the modem status of sixteen serial lines and tells the host when any of them changes. While scanning is on, it visits one line every four clocks. On each visit it compares the line's carrier, clear-to-send, secondary-receive and ring inputs against the values it stored on an earlier visit. When a line differs, the scanner parks on that line. It raises a done flag and one change flag for each signal that moved, and it asserts an interrupt if interrupts are enabled. The line's number appears in the low bits of the control/status register.

The host reaches the per-line modem controls through a second register: line enable, data terminal ready, request to send and secondary transmit. To do so it clears scan enable, polls until busy falls, and writes the line number to the control/status register. It can then read or write that line's status register. Afterwards the host writes interrupt enable together with scan enable, which clears done and restarts the scan from the line number written.

Top module: `modem_scan`

## Requirements
- R1: After reset the control/status register (select 0) reads 0x0000, every control output is 0 and `irq` is 0.
- R2: `irq` is high exactly when done (bit 7) and interrupt enable (bit 6) are both set. A host write that sets both bits forces an interrupt. A host write of done alone does not raise `irq`.
- R3: A control/status write that sets scan enable (bit 5) starts the scan at the line number written in bits 3:0. Each line takes 4 clocks and its compare commits on the 4th rising edge after the line was entered, so a change on line k is flagged 4*(k+1) clocks after the write when scanning starts at line 0. Lines are visited in ascending order and the scan wraps from 15 to 0. When no line differs, no interrupt occurs.
- R4: On a mismatch the scanner sets done and sets the change flag for each differing signal: bit 15 ring, bit 14 carrier, bit 13 clear-to-send, bit 12 secondary receive. It leaves the line number in bits 3:0, and then holds line and flags unchanged while done stays set.
- R5: Only the reported line's stored values are updated, so a later change on that line, including a return to the old level, is reported again.
- R6: Busy (bit 4) reads 1 while scanning is active and done is clear. After a write clears scan enable during active scanning, busy stays 1 for two more clocks and then reads 0.
- R7: The line status register (select 1) of the selected line reads bit 0 line enable, bit 1 DTR, bit 2 RTS, bit 3 secondary transmit, bit 4 secondary receive, bit 5 clear-to-send, bit 6 carrier and bit 7 ring, with the upper byte 0.
- R8: A line status write sets the selected line's four control outputs from data bits 3:0. It is ignored while busy reads 1.
- R9: Writing bit 11 (clear scan) zeroes every stored status value. Writing bit 10 (clear multiplexer) zeroes every control output. Both bits read back as 0.
- R10: Writing bit 8 (step) with a line number selects the following line, modulo 16.
- R11: With bit 9 (maintenance) set, the scanned and read status of each line loops back from its own controls: carrier from DTR, clear-to-send from RTS, secondary receive from secondary transmit, ring from line enable.
- R12: When a control/status write lands in the same cycle as a compare, the write wins and the compare is discarded with the stored values unchanged, so the change is found on the next visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control/status, 1 selects line status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| st_car | input | LINES | Carrier detect per line |
| st_cts | input | LINES | Clear-to-send per line |
| st_sr | input | LINES | Secondary receive per line |
| st_ring | input | LINES | Ring indicator per line |
| ctl_le | output | LINES | Line enable per line |
| ctl_dtr | output | LINES | Data terminal ready per line |
| ctl_rts | output | LINES | Request to send per line |
| ctl_st | output | LINES | Secondary transmit per line |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are the scanner committing a compare and the host writing the control/status register. The bench provokes this by arming a ring change on line 0, starting the scan, and timing a second control/status write so that it lands on the fourth edge, the edge where line 0 is compared. The collision is judged correct if done is still clear right after that write and the same change is then reported exactly four clocks later. A design that let the compare through would update the stored value, so the change would never be reported.

// File: rtl/modem_scan.sv
module modem_scan #(
  parameter int LINES = 16,
  parameter int DWELL = 4,
  parameter int DRAIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic [LINES-1:0] st_car,
  input  logic [LINES-1:0] st_cts,
  input  logic [LINES-1:0] st_sr,
  input  logic [LINES-1:0] st_ring,
  output logic [LINES-1:0] ctl_le,
  output logic [LINES-1:0] ctl_dtr,
  output logic [LINES-1:0] ctl_rts,
  output logic [LINES-1:0] ctl_st,
  output logic             irq
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int PW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam int DW = $clog2(DRAIN + 1);
  localparam logic [LW-1:0] LAST  = LW'(LINES - 1);
  localparam logic [PW-1:0] PLAST = PW'(DWELL - 1);

  logic [3:0]       flag_q;
  logic             done_q, ie_q, se_q, mnt_q;
  logic [LW-1:0]    line_q;
  logic [PW-1:0]    ph_q;
  logic [DW-1:0]    drain_q;
  logic [LINES-1:0] le_q, dtr_q, rts_q, st_q;
  logic [LINES-1:0] seen_car, seen_cts, seen_sr, seen_ring;

  function automatic logic [LW-1:0] nxt(input logic [LW-1:0] l);
    return (l == LAST) ? '0 : l + 1'b1;
  endfunction

  wire [LINES-1:0] eff_car  = mnt_q ? dtr_q : st_car;
  wire [LINES-1:0] eff_cts  = mnt_q ? rts_q : st_cts;
  wire [LINES-1:0] eff_sr   = mnt_q ? st_q  : st_sr;
  wire [LINES-1:0] eff_ring = mnt_q ? le_q  : st_ring;

  wire [3:0] cur  = {eff_ring[line_q], eff_car[line_q], eff_cts[line_q], eff_sr[line_q]};
  wire [3:0] old  = {seen_ring[line_q], seen_car[line_q], seen_cts[line_q], seen_sr[line_q]};
  wire [3:0] diff = cur ^ old;

  wire csr_wr = reg_wr & ~reg_sel;
  wire ls_wr  = reg_wr & reg_sel;
  wire run    = se_q & ~done_q;
  wire cmp    = run & (ph_q == PLAST);
  wire hit    = cmp & (|diff) & ~csr_wr;
  wire adv    = cmp & ~(|diff) & ~csr_wr;
  wire busy   = run | (drain_q != '0);

  logic unused_bits;
  assign unused_bits = reg_wdata[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      done_q  <= 1'b0;
      ie_q    <= 1'b0;
      se_q    <= 1'b0;
      mnt_q   <= 1'b0;
      line_q  <= '0;
      ph_q    <= '0;
      drain_q <= '0;
    end else if (csr_wr) begin
      flag_q  <= reg_wdata[15:12];
      mnt_q   <= reg_wdata[9];
      done_q  <= reg_wdata[7];
      ie_q    <= reg_wdata[6];
      se_q    <= reg_wdata[5];
      line_q  <= reg_wdata[8] ? nxt(reg_wdata[LW-1:0]) : reg_wdata[LW-1:0];
      ph_q    <= '0;
      drain_q <= (run && !reg_wdata[5]) ? DW'(DRAIN) : '0;
    end else begin
      if (drain_q != '0) drain_q <= drain_q - 1'b1;
      if (run) begin
        if (hit) begin
          done_q <= 1'b1;
          flag_q <= flag_q | diff;
          ph_q   <= '0;
        end else if (adv) begin
          line_q <= nxt(line_q);
          ph_q   <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_car  <= '0;
      seen_cts  <= '0;
      seen_sr   <= '0;
      seen_ring <= '0;
    end else if (csr_wr && reg_wdata[11]) begin
      seen_car  <= '0;
      seen_cts  <= '0;
      seen_sr   <= '0;
      seen_ring <= '0;
    end else if (hit) begin
      seen_ring[line_q] <= cur[3];
      seen_car[line_q]  <= cur[2];
      seen_cts[line_q]  <= cur[1];
      seen_sr[line_q]   <= cur[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q  <= '0;
      dtr_q <= '0;
      rts_q <= '0;
      st_q  <= '0;
    end else if (csr_wr && reg_wdata[10]) begin
      le_q  <= '0;
      dtr_q <= '0;
      rts_q <= '0;
      st_q  <= '0;
    end else if (ls_wr && !busy) begin
      le_q[line_q]  <= reg_wdata[0];
      dtr_q[line_q] <= reg_wdata[1];
      rts_q[line_q] <= reg_wdata[2];
      st_q[line_q]  <= reg_wdata[3];
    end
  end

  wire [15:0] csr_rd = {flag_q, 2'b00, mnt_q, 1'b0, done_q, ie_q, se_q, busy, 4'(line_q)};
  wire [15:0] ls_rd  = {8'h00, eff_ring[line_q], eff_car[line_q], eff_cts[line_q], eff_sr[line_q],
                        st_q[line_q], rts_q[line_q], dtr_q[line_q], le_q[line_q]};

  assign reg_rdata = reg_sel ? ls_rd : csr_rd;
  assign irq       = done_q & ie_q;
  assign ctl_le    = le_q;
  assign ctl_dtr   = dtr_q;
  assign ctl_rts   = rts_q;
  assign ctl_st    = st_q;

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (line_q == nxt($past(line_q)) && ph_q == '0 && !done_q));

  a_r4_hit_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (done_q && flag_q != 4'b0000 && line_q == $past(line_q)));

  a_r4_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !csr_wr) |=> (done_q && $stable(line_q) && $stable(flag_q)));

  a_r6_drain_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_q != '0 && !csr_wr) |=> (drain_q == $past(drain_q) - DW'(1)));

  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(csr_wr && reg_wdata[10])) |=>
      ($stable(le_q) && $stable(dtr_q) && $stable(rts_q) && $stable(st_q)));

  a_r9_clear_mux: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && reg_wdata[10]) |=> (le_q == '0 && dtr_q == '0 && rts_q == '0 && st_q == '0));

  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && csr_wr) |=> (done_q == $past(reg_wdata[7]) && $stable(seen_car) && $stable(seen_ring)));
endmodule

// File: tb/modem_scan_bench.sv
`timescale 1ns/1ps
module modem_scan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] car = '0, cts = '0, sr = '0, ring = '0;
  logic [15:0] c_le, c_dtr, c_rts, c_st;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [3:0] mseen [16];
  logic [15:0] v;
  int n, k;
  logic [3:0] m;

  always #4 clk = ~clk;

  modem_scan u_modem_scan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_car(car), .st_cts(cts), .st_sr(sr), .st_ring(ring),
    .ctl_le(c_le), .ctl_dtr(c_dtr), .ctl_rts(c_rts), .ctl_st(c_st),
    .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] q);
    reg_sel = sel;
    #1;
    q = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic wait_irq(output int cnt);
    cnt = 0;
    while (!irq && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  function automatic logic [3:0] cur(input int l);
    return {ring[l], car[l], cts[l], sr[l]};
  endfunction

  function automatic int first_diff();
    for (int l = 0; l < 16; l++) if (cur(l) != mseen[l]) return l;
    return 16;
  endfunction

  function automatic logic [15:0] park_csr(input int l, input logic [3:0] d);
    return {d, 12'h000} | 16'h00E0 | 16'(l);
  endfunction

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    for (int l = 0; l < 16; l++) mseen[l] = 4'h0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, v); chk("R1 csr", v, 16'h0000);
    chk("R1 ctl", {c_le, c_dtr, c_rts, c_st}, 64'h0);
    chk("R1 irq", irq, 1'b0);

    // R2 forced interrupt
    wr(0, 16'h00C0); chk("R2 forced irq", irq, 1'b1);
    rd(0, v); chk("R2 csr", v, 16'h00C0);
    wr(0, 16'h0080); chk("R2 done without ie", irq, 1'b0);
    wr(0, 16'h0000);

    // R7 R8 line status access
    wr(0, 16'h0005);
    wr(1, 16'h000B);
    car[5] = 1'b1;
    chk("R8 le", c_le, 16'h0020); chk("R8 dtr", c_dtr, 16'h0020);
    chk("R8 rts", c_rts, 16'h0000); chk("R8 st", c_st, 16'h0020);
    rd(1, v); chk("R7 line status", v, 16'h004B);

    // R9 clear multiplexer
    wr(0, 16'h0400);
    chk("R9 clear mux", {c_le, c_dtr, c_rts, c_st}, 64'h0);
    rd(0, v); chk("R9 strobe reads 0", v, 16'h0000);

    // R10 step
    wr(0, 16'h010F); rd(0, v); chk("R10 step wrap", v, 16'h0000);
    wr(0, 16'h0107); rd(0, v); chk("R10 step", v, 16'h0008);

    // R3 R4 carrier change on line 5
    wr(0, 16'h0060); wait_irq(n);
    chk("R3 latency line5", n, 24);
    rd(0, v); chk("R4 park csr", v, park_csr(5, 4'b0100));
    repeat (10) @(negedge clk);
    rd(0, v); chk("R4 held while done", v, park_csr(5, 4'b0100));
    mseen[5] = cur(5);

    // R6 busy and R8 ignored while busy
    wr(0, 16'h0060);
    rd(0, v); chk("R6 busy while scanning", v[4], 1'b1);
    wr(1, 16'h000F);
    chk("R8 write ignored when busy", {c_le, c_dtr, c_rts, c_st}, 64'h0);
    wr(0, 16'h0000);
    rd(0, v); chk("R6 busy drain 1", v[4], 1'b1);
    @(negedge clk); rd(0, v); chk("R6 busy drain 2", v[4], 1'b1);
    @(negedge clk); rd(0, v); chk("R6 busy low", v[4], 1'b0);

    // R5 return to old level is reported again
    car[5] = 1'b0;
    wr(0, 16'h0060); wait_irq(n);
    chk("R5 latency", n, 24);
    rd(0, v); chk("R5 csr", v, park_csr(5, 4'b0100));
    mseen[5] = cur(5);

    // R11 maintenance loopback
    wr(0, 16'h0203);
    wr(1, 16'h0002);
    rd(1, v); chk("R11 loop read", v, 16'h0042);
    wr(0, 16'h0260); wait_irq(n);
    chk("R11 latency", n, 16);
    rd(0, v); chk("R11 csr", v, park_csr(3, 4'b0100) | 16'h0200);

    // R9 clear scan
    wr(0, 16'h0400);
    wr(0, 16'h0800);
    rd(0, v); chk("R9 clear scan reads 0", v, 16'h0000);
    for (int l = 0; l < 16; l++) mseen[l] = 4'h0;
    wr(0, 16'h0060);
    repeat (72) @(negedge clk);
    chk("R9 no report after clear scan", irq, 1'b0);
    wr(0, 16'h0000);

    // R12 collision of host write with compare
    ring[0] = 1'b1;
    wr(0, 16'h0060);
    @(negedge clk); @(negedge clk);
    wr(0, 16'h0060);
    chk("R12 compare discarded", irq, 1'b0);
    wait_irq(n);
    chk("R12 rediscovered", n, 4);
    rd(0, v); chk("R12 csr", v, park_csr(0, 4'b1000));
    mseen[0] = cur(0);

    // R3 R4 R5 random patterns
    for (int t = 0; t < 20; t++) begin
      wr(0, 16'h0000);
      for (int l = 0; l < 16; l++) begin
        if ($urandom % 4 == 0) begin
          m = 4'($urandom % 15 + 1);
          {ring[l], car[l], cts[l], sr[l]} = cur(l) ^ m;
        end
      end
      for (int p = 0; p < 17; p++) begin
        k = first_diff();
        wr(0, 16'h0060);
        if (k == 16) begin
          repeat (68) @(negedge clk);
          chk("R3 quiet pass", irq, 1'b0);
          break;
        end
        wait_irq(n);
        chk("R3 random latency", n, 4 * (k + 1));
        rd(0, v); chk("R4 random csr", v, park_csr(k, cur(k) ^ mseen[k]));
        mseen[k] = cur(k);
      end
    end

    finished = 1;
    report();
  end
endmodule